// File: doc/BRIEF.md
# Memory Sub-Chip-Select Decoder

This block drives one active-low sub-chip-select pin that marks an address window inside a larger external memory area. A small configuration register sets the window up. One bit steers the decode to the strobe of area 0 or of area 2. A two-bit capacity code sets how many upper address bits take part in the compare. A four-bit start field gives the window base in units of 4 MB. While the chosen area strobe is low and the compared address bits match, the pin goes low.

The register sits on a simple register bus with a select, a write enable and two byte strobes. Only a power-on reset clears it. The manual-reset and standby inputs leave it as it is. The physical pin is shared with a general-purpose port bit, and a two-bit port mode input picks which of the two functions reaches the pin.

Top module: `mem_subcs_dec`

## Requirements
- R1: A cycle with `por_rst_i` high clears the configuration, so the register reads back 0x0000 from the next cycle on.
- R2: `man_rst_i` and `standby_i` leave the stored configuration unchanged, and the read-back value stays the same while they are high.
- R3: Read-back bits 15:7 are always 0. A write that sets those bits, or a write with only `reg_be_i[1]` set, stores nothing in them.
- R4: A write happens when `reg_sel_i`, `reg_we_i` and `reg_be_i[0]` are all high. It loads `reg_wdata_i[6:0]`: bit 6 is the area select, bits 5:4 are the capacity code and bits 3:0 are the start field, which maps to A25..A22. The new value shows on read-back and in the decode from the next cycle. With `reg_be_i[0]` low, the write has no effect.
- R5: With bit 6 = 0, only a low `cs0_n_i` qualifies the decode. With bit 6 = 1, only a low `cs2_n_i` qualifies it. The strobe of the other area has no effect.
- R6: The capacity code sets which bits take part in the compare. Code 00 (32 Mbit) compares A25:A22, code 01 (64 Mbit) compares A25:A23, code 10 (128 Mbit) compares A25:A24 and code 11 (256 Mbit) compares A25 only. Start-field bits below the window are ignored.
- R7: The sub-chip-select is active low and combinational. It is low only while the selected strobe is low and the compared bits match. Otherwise it is high.
- R8: When `port_mode_i` is 00, `pin_o` carries the sub-chip-select. For any other mode value, `pin_o` carries `port_dout_i`.
- R9: `reg_rdata_o` shows the configuration zero-extended to 16 bits while `reg_sel_i` is high, and 0 while it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_rst_i | input | 1 | Synchronous power-on reset, active high |
| man_rst_i | input | 1 | Manual reset, has no effect on the register |
| standby_i | input | 1 | Standby indication, has no effect on the register |
| reg_sel_i | input | 1 | Register address match |
| reg_we_i | input | 1 | Register write enable |
| reg_be_i | input | 2 | Byte strobes (bit 0 = bits 7:0, bit 1 = bits 15:8) |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data |
| bus_addr_i | input | 26 | Bus byte address |
| cs0_n_i | input | 1 | Area 0 strobe, active low |
| cs2_n_i | input | 1 | Area 2 strobe, active low |
| port_mode_i | input | 2 | Pin function select, 00 = sub-chip-select |
| port_dout_i | input | 1 | Port output value |
| pin_o | output | 1 | Shared pin output |

## Verification
The only state in the block is the seven-bit configuration. Any corruption of it shows up at the read port in the same cycle as soon as `reg_sel_i` is high. It also shows up on `pin_o` as soon as an address probes the edge of the window, where a wrong capacity or start bit moves the boundary. The bench therefore checks read data and the pin on every cycle, not only at the end of a sequence. It probes addresses just inside and just outside every window edge, for each capacity code, so that a bad mask bit fails at once.

// File: rtl/subcs_pkg.sv
package subcs_pkg;
  localparam int CAP_W   = 2;
  localparam int START_W = 4;
  localparam int CFG_W   = 1 + CAP_W + START_W;

  typedef enum logic [CAP_W-1:0] {
    CAP_32M  = 2'b00,
    CAP_64M  = 2'b01,
    CAP_128M = 2'b10,
    CAP_256M = 2'b11
  } cap_code_e;

  typedef struct packed {
    logic                area2;
    cap_code_e           cap;
    logic [START_W-1:0]  start;
  } subcs_cfg_t;
endpackage

// File: rtl/subcs_cfg_reg.sv
module subcs_cfg_reg
  import subcs_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              por_rst_i,
  input  logic              man_rst_i,
  input  logic              standby_i,
  input  logic              sel_i,
  input  logic              we_i,
  input  logic [1:0]        be_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output subcs_cfg_t        cfg_o
);
  logic       wr_lo;
  subcs_cfg_t cfg_q;

  assign wr_lo = sel_i & we_i & be_i[0];

  // Reserved write bits, the upper byte strobe, manual reset and standby
  // intentionally reach no storage.
  logic unused_inputs;
  assign unused_inputs = ^{wdata_i[DATA_W-1:CFG_W], be_i[1], man_rst_i, standby_i};

  always_ff @(posedge clk) begin
    if (por_rst_i) begin
      cfg_q <= '0;
    end else if (wr_lo) begin
      cfg_q <= subcs_cfg_t'(wdata_i[CFG_W-1:0]);
    end
  end

  assign cfg_o   = cfg_q;
  assign rdata_o = sel_i ? DATA_W'(cfg_q) : '0;

  // R2 / R3: anything but a low-byte write leaves the configuration intact
  p_hold_r2: assert property (@(posedge clk) disable iff (por_rst_i)
    !wr_lo |=> $stable(cfg_q));

  // R4: a low-byte write lands on the next cycle
  p_load_r4: assert property (@(posedge clk) disable iff (por_rst_i)
    wr_lo |=> (cfg_q == $past(wdata_i[CFG_W-1:0])));
endmodule

// File: rtl/subcs_addr_match.sv
module subcs_addr_match
  import subcs_pkg::*;
#(
  parameter int ADDR_W = 26
) (
  input  logic              clk,
  input  logic              por_rst_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  subcs_cfg_t        cfg_i,
  output logic              hit_o
);
  localparam int FIELD_LSB = ADDR_W - START_W;

  logic [START_W-1:0] cmp_en;
  logic [START_W-1:0] diff;

  for (genvar i = 0; i < START_W; i++) begin : g_bit
    // Bit i of the start field (address bit FIELD_LSB+i) is compared only
    // when it lies at or above the window size chosen by the capacity code.
    assign cmp_en[i] = ($unsigned(i) >= 32'(cfg_i.cap));
    assign diff[i]   = addr_i[FIELD_LSB+i] ^ cfg_i.start[i];
  end

  assign hit_o = ~|(diff & cmp_en);

  // R6: in the largest window only the top address bit decides
  p_top_only_r6: assert property (@(posedge clk) disable iff (por_rst_i)
    ((cfg_i.cap == CAP_256M) && (addr_i[ADDR_W-1] == cfg_i.start[START_W-1])) |-> hit_o);
endmodule

// File: rtl/subcs_pin_mux.sv
module subcs_pin_mux #(
  parameter int MODE_W = 2
) (
  input  logic [MODE_W-1:0] mode_i,
  input  logic              subcs_n_i,
  input  logic              port_dout_i,
  output logic              pin_o
);
  always_comb begin
    if (mode_i == '0) pin_o = subcs_n_i;
    else              pin_o = port_dout_i;
  end
endmodule

// File: rtl/mem_subcs_dec.sv
module mem_subcs_dec
  import subcs_pkg::*;
#(
  parameter int ADDR_W = 26,
  parameter int DATA_W = 16,
  parameter int MODE_W = 2
) (
  input  logic              clk,
  input  logic              por_rst_i,
  input  logic              man_rst_i,
  input  logic              standby_i,
  input  logic              reg_sel_i,
  input  logic              reg_we_i,
  input  logic [1:0]        reg_be_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              cs0_n_i,
  input  logic              cs2_n_i,
  input  logic [MODE_W-1:0] port_mode_i,
  input  logic              port_dout_i,
  output logic              pin_o
);
  subcs_cfg_t cfg;
  logic       hit;
  logic       area_act;
  logic       subcs_n;

  subcs_cfg_reg #(.DATA_W(DATA_W)) u_cfg (
    .clk       (clk),
    .por_rst_i (por_rst_i),
    .man_rst_i (man_rst_i),
    .standby_i (standby_i),
    .sel_i     (reg_sel_i),
    .we_i      (reg_we_i),
    .be_i      (reg_be_i),
    .wdata_i   (reg_wdata_i),
    .rdata_o   (reg_rdata_o),
    .cfg_o     (cfg)
  );

  subcs_addr_match #(.ADDR_W(ADDR_W)) u_match (
    .clk       (clk),
    .por_rst_i (por_rst_i),
    .addr_i    (bus_addr_i),
    .cfg_i     (cfg),
    .hit_o     (hit)
  );

  assign area_act = cfg.area2 ? ~cs2_n_i : ~cs0_n_i;
  assign subcs_n  = ~(area_act & hit);

  subcs_pin_mux #(.MODE_W(MODE_W)) u_mux (
    .mode_i      (port_mode_i),
    .subcs_n_i   (subcs_n),
    .port_dout_i (port_dout_i),
    .pin_o       (pin_o)
  );

  // R7: with both area strobes idle the select stays high
  p_idle_high_r7: assert property (@(posedge clk) disable iff (por_rst_i)
    (cs0_n_i && cs2_n_i) |-> subcs_n);

  // R8: any non-zero mode passes the port value to the pin
  p_port_pass_r8: assert property (@(posedge clk) disable iff (por_rst_i)
    (port_mode_i != '0) |-> (pin_o == port_dout_i));

  // R5: the area 2 strobe cannot assert the select while area 0 is chosen
  p_area_r5: assert property (@(posedge clk) disable iff (por_rst_i)
    (!cfg.area2 && cs0_n_i) |-> subcs_n);
endmodule

// File: tb/sim_mem_subcs_dec.sv
`timescale 1ns/1ps
module sim_mem_subcs_dec;
  logic        clk = 1'b0;
  logic        por_rst = 1'b1, man_rst = 1'b0, standby = 1'b0;
  logic        sel = 1'b0, we = 1'b0;
  logic [1:0]  be = 2'b00;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [25:0] addr = '0;
  logic        cs0_n = 1'b1, cs2_n = 1'b1;
  logic [1:0]  mode = 2'b00;
  logic        pdout = 1'b0;
  logic        pin;

  int n_checks = 0, n_fail = 0;
  int mcfg = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  mem_subcs_dec u0 (
    .clk(clk), .por_rst_i(por_rst), .man_rst_i(man_rst), .standby_i(standby),
    .reg_sel_i(sel), .reg_we_i(we), .reg_be_i(be), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .bus_addr_i(addr), .cs0_n_i(cs0_n), .cs2_n_i(cs2_n),
    .port_mode_i(mode), .port_dout_i(pdout), .pin_o(pin)
  );

  function automatic logic model_pin();
    int cap, start, area2;
    logic strobe, inwin, sc_n;
    cap    = (mcfg >> 4) & 3;
    start  = mcfg & 15;
    area2  = (mcfg >> 6) & 1;
    strobe = area2 ? !cs2_n : !cs0_n;
    inwin  = ((int'(addr) >> (22 + cap)) == (start >> cap));
    sc_n   = !(strobe && inwin);
    return (mode == 2'b00) ? sc_n : pdout;
  endfunction

  // One cycle: compare outputs against the model, then let the edge update it.
  task automatic step(input string req, input bit chk = 1);
    logic [15:0] exp_rd;
    logic        exp_pin;
    #1;
    exp_rd  = sel ? 16'(mcfg) : 16'h0000;
    exp_pin = model_pin();
    if (chk) begin
      n_checks++;
      if (rdata !== exp_rd || pin !== exp_pin) begin
        n_fail++;
        $display("FAIL %s: rdata=%h pin=%b expected rdata=%h pin=%b", req, rdata, pin, exp_rd, exp_pin);
      end
    end
    @(posedge clk);
    if (por_rst) mcfg = 0;
    else if (sel && we && be[0]) mcfg = int'(wdata) & 8'h7F;
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] b, input logic [15:0] d, input string req);
    sel = 1; we = 1; be = b; wdata = d;
    step(req);
    we = 0; be = 2'b00;
    step(req);
  endtask

  // Probe both edges of the configured window under each strobe pair.
  task automatic sweep(input string req);
    int cap, start, lo, sz;
    cap = (mcfg >> 4) & 3; start = mcfg & 15;
    sz = 1 << (22 + cap);
    lo = (start >> cap) << (22 + cap);
    for (int s = 0; s < 4; s++) begin
      cs0_n = s[0]; cs2_n = s[1];
      addr = 26'(lo);            step(req);
      addr = 26'(lo + sz - 1);   step(req);
      addr = 26'(lo + sz);       step(req);
      addr = 26'(lo - 1);        step(req);
      addr = 26'((start << 22)); step(req);
    end
    cs0_n = 1; cs2_n = 1;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    sel = 1;
    step("R1", 0);
    step("R1", 0);
    por_rst = 0;
    step("R1");                     // reset value reads 0x0000
    wr(2'b11, 16'hFFFF, "R3");      // reserved bits stay 0
    por_rst = 1; step("R1"); por_rst = 0; step("R1");
    wr(2'b01, 16'h0015, "R4");      // area 0, 64 Mbit, start 0101
    sweep("R6");
    wr(2'b10, 16'h007F, "R3");      // upper byte strobe only: no change
    wr(2'b00, 16'h007F, "R4");      // no strobes: no change
    sel = 1; we = 1; be = 2'b01; wdata = 16'h004A; step("R4");
    we = 0; be = 2'b00; step("R4");  // new value visible next cycle
    sweep("R5");
    for (int c = 0; c < 4; c++) begin
      for (int st = 0; st < 16; st += 5) begin
        wr(2'b01, 16'((c << 4) | st), "R6");
        sweep("R6");
        wr(2'b01, 16'(64 | (c << 4) | st), "R5");
        sweep("R5");
      end
    end
    wr(2'b01, 16'h0027, "R7");
    man_rst = 1; step("R2"); step("R2");
    standby = 1; step("R2"); man_rst = 0; step("R2"); standby = 0;
    sweep("R2");
    sel = 0; step("R9"); step("R9");
    sel = 1; step("R9");
    addr = 26'h0C00000; cs0_n = 1; cs2_n = 1; step("R7");
    for (int m = 0; m < 4; m++) begin
      mode = 2'(m);
      for (int d = 0; d < 2; d++) begin
        pdout = d[0];
        cs2_n = 1; step("R8");
        cs2_n = 0; step("R8");
      end
    end
    mode = 0; cs2_n = 1;
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule